// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block takes a serial 2.048 Mbit/s E1 (PCM30) line, one bit per clock, and finds basic frame alignment. While hunting, it compares the last seven received bits against the 7-bit alignment pattern at every bit position. A hit starts a confirmation sequence. One frame later, the second bit of the non-alignment word must be set. One frame after that, the alignment pattern must appear again at the same phase. If either test fails, the candidate is dropped and the hunt resumes on the next bit.

Once alignment is confirmed, the active-low sync output goes low. The block then publishes the position of the bit currently on the line as a bit-in-slot, slot-in-frame and frame count. It also raises a start-of-frame strobe and a flag that marks the odd (non-alignment) frames, for use by later multiframe logic. While locked, the alignment word is re-checked in every even frame. Three errored alignment words in a row drop the lock, and the hunt starts again.

Top module: `e1_frame_align`

## Requirements
- R1: While reset is held and in the first cycle after it, sync_n is 1, and sof, nfas_frame, frame_cnt, ts_cnt and bit_cnt are all 0.
- R2: The hunt covers every bit phase. If an alignment word (transmitted bits 2..8 = 0011011) is followed one frame later by a non-alignment word whose second bit is 1, and one frame after that by another alignment word, sync_n goes to 0 on the clock edge that samples bit 8 of that last word.
- R3: The first transmitted bit of an alignment word is not compared; either value gives the same result.
- R4: If the second transmitted bit of the non-alignment word after a candidate is 0, the candidate is dropped and the hunt restarts with the next bit.
- R5: If the alignment word one double-frame after the candidate is wrong, the candidate is dropped and the hunt restarts with the next bit.
- R6: While locked, bit_cnt (0..7, 0 = first transmitted bit of a slot) and ts_cnt (0..NUM_TS-1) give the position of the bit now on rx_bit. frame_cnt counts frames modulo 2^FRAME_CNT_W, with frame 0 being the candidate's alignment frame.
- R7: While locked, sof is 1 exactly when bit_cnt and ts_cnt are both 0. nfas_frame is 1 during non-alignment frames, which are the odd values of frame_cnt.
- R8: While locked, LOSS_LIMIT consecutive errored alignment words set sync_n to 1 on the edge that samples the last of them. A correct word clears the error run.
- R9: While not locked, sof, nfas_frame, frame_cnt, ts_cnt and bit_cnt are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial data, first transmitted bit of a slot first |
| sync_n | output | 1 | 0 while basic frame alignment is held |
| sof | output | 1 | Strobe on the first bit of each frame while locked |
| nfas_frame | output | 1 | High during non-alignment (odd) frames while locked |
| frame_cnt | output | FRAME_CNT_W | Frame number modulo 2^FRAME_CNT_W |
| ts_cnt | output | $clog2(NUM_TS) | Timeslot of the current bit |
| bit_cnt | output | 3 | Bit within the timeslot |

## Verification
The bench builds the block with NUM_TS = 4, which gives 32-bit frames, and keeps FRAME_CNT_W = 4 and LOSS_LIMIT = 3. With frames that short, the bench can start the stream at every one of the 64 phases of a double frame. For each phase it runs four scenarios: a clean line, a cleared bit in the non-alignment word, a corrupted second alignment word, and a locked run with error bursts of two and then three words. Lock and loss points and all counter values are derived arithmetically from the start phase, so a clean run, both abort paths, the error-run reset, loss of lock and reacquisition are all checked on every cycle.

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int NUM_TS      = 32,
  parameter int FRAME_CNT_W = 4,
  parameter int LOSS_LIMIT  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_bit,
  output logic                      sync_n,
  output logic                      sof,
  output logic                      nfas_frame,
  output logic [FRAME_CNT_W-1:0]    frame_cnt,
  output logic [$clog2(NUM_TS)-1:0] ts_cnt,
  output logic [2:0]                bit_cnt
);
  localparam int FRAME_BITS = NUM_TS * 8;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int CW         = PW + FRAME_CNT_W;
  localparam int EW         = $clog2(LOSS_LIMIT + 1);
  localparam logic [6:0] ALIGN_PAT = 7'b0011011;

  typedef enum logic [1:0] {HUNT, CHK_ODD, CHK_EVEN, LOCKED} state_t;

  state_t         st;
  logic [6:0]     sr;
  logic [CW-1:0]  cnt;
  logic [EW-1:0]  err_run;

  logic [7:0] word;
  logic       pat_hit, word_end, odd_frm, locked;

  assign word     = {sr, rx_bit};
  assign pat_hit  = (word[6:0] == ALIGN_PAT);
  assign word_end = (cnt[PW-1:0] == PW'(7));
  assign odd_frm  = cnt[PW];
  assign locked   = (st == LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= HUNT;
      sr      <= '1;
      cnt     <= '0;
      err_run <= '0;
    end else begin
      sr  <= word[6:0];
      cnt <= cnt + CW'(1);
      case (st)
        HUNT:
          if (pat_hit) begin
            cnt <= CW'(8);
            st  <= CHK_ODD;
          end
        CHK_ODD:
          if (word_end && odd_frm)
            st <= word[6] ? CHK_EVEN : HUNT;
        CHK_EVEN:
          if (word_end && !odd_frm) begin
            st      <= pat_hit ? LOCKED : HUNT;
            err_run <= '0;
          end
        LOCKED:
          if (word_end && !odd_frm) begin
            if (pat_hit) begin
              err_run <= '0;
            end else if (err_run == EW'(LOSS_LIMIT - 1)) begin
              err_run <= '0;
              st      <= HUNT;
            end else begin
              err_run <= err_run + EW'(1);
            end
          end
        default: st <= HUNT;
      endcase
    end
  end

  assign sync_n     = ~locked;
  assign sof        = locked && (cnt[PW-1:0] == '0);
  assign nfas_frame = locked && odd_frm;
  assign frame_cnt  = locked ? cnt[CW-1:PW] : '0;
  assign ts_cnt     = locked ? cnt[PW-1:3] : '0;
  assign bit_cnt    = locked ? cnt[2:0] : '0;
endmodule

module e1_frame_align_chk #(
  parameter int NUM_TS      = 32,
  parameter int FRAME_CNT_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sync_n,
  input logic                      sof,
  input logic                      nfas_frame,
  input logic [FRAME_CNT_W-1:0]    frame_cnt,
  input logic [$clog2(NUM_TS)-1:0] ts_cnt,
  input logic [2:0]                bit_cnt
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> (bit_cnt == 3'd0 && ts_cnt == '0 && frame_cnt == '0 && !sof && !nfas_frame)); // R9
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && $past(!sync_n)) |-> (bit_cnt == $past(bit_cnt) + 3'd1)); // R6
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && $past(!sync_n) && $past(bit_cnt) == 3'd7) |-> (ts_cnt == $past(ts_cnt) + 1'b1)); // R6
  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && $past(!sync_n) && sof) |-> (nfas_frame != $past(nfas_frame))); // R7
  AST_LOCK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> (bit_cnt == 3'd0 && ts_cnt == 1 && !nfas_frame)); // R2
  AST_LOSS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> ($past(bit_cnt) == 3'd7 && $past(ts_cnt) == '0 && !$past(nfas_frame))); // R8
endmodule

bind e1_frame_align e1_frame_align_chk #(.NUM_TS(NUM_TS), .FRAME_CNT_W(FRAME_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sof(sof), .nfas_frame(nfas_frame),
  .frame_cnt(frame_cnt), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt)
);

// File: tb/test_e1_frame_align.sv
`timescale 1ns/1ps
module test_e1_frame_align;
  localparam int NTS = 4;
  localparam int F   = NTS * 8;
  localparam int DF  = 2 * F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1;
  logic sync_n, sof, nfas_frame;
  logic [3:0] frame_cnt;
  logic [1:0] ts_cnt;
  logic [2:0] bit_cnt;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int n0 = 0;
  int mode = 0;

  always #4 clk = ~clk;

  e1_frame_align #(.NUM_TS(NTS), .FRAME_CNT_W(4), .LOSS_LIMIT(3)) i_e1_frame_align (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sync_n(sync_n), .sof(sof),
    .nfas_frame(nfas_frame), .frame_cnt(frame_cnt), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt)
  );

  function automatic bit fas_bad(int n);
    if (mode == 2) return n == n0 + 1;
    if (mode == 3) return n == n0+2 || n == n0+3 || n == n0+5 || n == n0+6 || n == n0+7;
    return 1'b0;
  endfunction

  function automatic logic bit_at(int i);
    int n = i / DF;
    int pos = i % DF;
    int w = pos % F;
    logic [7:0] fas;
    if (w >= 8) return 1'b1;
    if (pos < F) begin
      fas = {1'(n % 2), 7'b0011011};   // R3: first bit alternates
      if (w == 1 && fas_bad(n)) return 1'b1;
      return fas[7-w];
    end
    if (w == 1) return (mode == 1 && n == n0) ? 1'b0 : 1'b1;
    return 1'b1;
  endfunction

  function automatic int edge_of(int n, int p);
    return n * DF + 7 - p;
  endfunction

  task automatic check(input logic [11:0] got, input logic [11:0] exp, input string tag,
                       input int p, input int j);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d phase=%0d step=%0d got=%h exp=%h", tag, mode, p, j, got, exp);
    end
  endtask

  task automatic run(input int m, input int p);
    int len, nc, rel;
    bit lk;
    logic [11:0] exp;
    string tag;
    mode = m;
    n0 = (p <= 1) ? 0 : 1;
    rst_n = 1'b0;
    rx_bit = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check({sync_n, sof, nfas_frame, frame_cnt, ts_cnt, bit_cnt}, 12'h800, "R1", p, -1);
    rst_n = 1'b1;
    case (m)
      0: begin len = edge_of(n0+3, p); tag = "R2 R3 R6 R7 R9"; end
      1: begin len = edge_of(n0+4, p); tag = "R4"; end
      2: begin len = edge_of(n0+5, p); tag = "R5"; end
      default: begin len = edge_of(n0+10, p); tag = "R8"; end
    endcase
    for (int j = 0; j < len; j++) begin
      rx_bit = bit_at(p + j);
      @(posedge clk);
      #2;
      nc = 0;
      case (m)
        0: begin lk = j >= edge_of(n0+1, p); nc = n0; end
        1: begin lk = j >= edge_of(n0+2, p); nc = n0 + 1; end
        2: begin lk = j >= edge_of(n0+3, p); nc = n0 + 2; end
        default: begin
          if (j >= edge_of(n0+9, p)) begin lk = 1'b1; nc = n0 + 8; end
          else begin lk = (j >= edge_of(n0+1, p)) && (j < edge_of(n0+7, p)); nc = n0; end
        end
      endcase
      if (lk) begin
        rel = p + j + 1 - nc * DF;
        exp = {1'b0, 1'(rel % F == 0), 1'((rel / F) % 2), 4'((rel / F) % 16),
               2'((rel / 8) % NTS), 3'(rel % 8)};
      end else begin
        exp = 12'h800;
      end
      check({sync_n, sof, nfas_frame, frame_cnt, ts_cnt, bit_cnt}, exp, tag, p, j);
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < DF; p++)
        run(m, p);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog expired got=%0d cycles exp<190000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end
endmodule